// File: doc/BRIEF.md
# Supervisor Interrupt View and Virtual-Pending Aliasing Unit

This unit sits beside the machine interrupt registers of a CPU with an advanced interrupt architecture. It builds the supervisor views of the pending and enable registers from the machine copies. It also keeps the storage for the machine virtual-pending register, its per-bit enable register and a shadow supervisor-enable register. The machine pending, enable and delegation registers live outside the unit. They arrive as plain inputs. Writes that must reach them leave as per-bit strobes with data, and the owner of those registers applies them on the same rising edge.

Each bit of the supervisor views picks its source on its own. A delegated bit shows the machine register. A bit that is undelegated but has its virtual enable set shows the virtual-pending bit or the shadow enable bit. Any other bit reads as zero. One access port with a 3-bit select reaches the four registers. Reads are combinational. Updates land on the next rising clock edge.

Top module: `sirq_alias`

## Requirements
- R1: A synchronous active-high reset clears the stored virtual-pending, virtual-enable and shadow-enable registers to zero.
- R2: A read with select 0 (supervisor pending) returns, bit by bit, the virtual-pending bit where delegation is 0 and the virtual enable is 1. It returns the machine pending bit ANDed with delegation everywhere else.
- R3: A read with select 1 (supervisor enable) returns the shadow-enable bit where delegation is 0 and the virtual enable is 1. It returns the machine enable bit ANDed with delegation everywhere else.
- R4: Bits 2, 6, 10 and 12 always read as zero through selects 0 and 1. Writes through those selects never strobe or change those bits.
- R5: A write with select 1 loads the shadow-enable bits that are aliased, i.e. delegation 0 and virtual enable 1. It strobes the machine enable bits where delegation is 1. It changes nothing else.
- R6: A write with select 0 strobes the machine pending bits that are both delegated and writable in the effective mask. It loads the virtual-pending bits that are aliased.
- R7: A read with select 2 returns the stored virtual-pending value, with two exceptions. Bit 1 returns machine pending bit 1 while virtual enable bit 1 is clear. Bit 5 returns machine pending bit 5 when that bit is writable, and zero otherwise.
- R8: A write with select 2 loads all virtual-pending bits. In the same cycle it strobes machine pending bits 1 and 9 where the virtual enable bit is clear, and bit 5 where that bit is writable.
- R9: A write with select 3 loads the virtual-enable register. The effective machine-pending write mask equals the input mask, except that bit 9 is cleared while virtual enable bit 9 is set.
- R10: A request with select 4 to 7 returns zero read data and raises the illegal flag in the same cycle. It issues no strobe and changes no stored register.
- R11: With no request, read data is zero, the illegal flag is low and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mip_i | input | NB | Current machine pending bits |
| mie_i | input | NB | Current machine enable bits |
| mideleg_i | input | NB | Interrupt delegation bits |
| mip_wmask_i | input | NB | Base writable mask of machine pending |
| csr_req_i | input | 1 | Access request |
| csr_we_i | input | 1 | Access is a write |
| csr_sel_i | input | 3 | 0 sip, 1 sie, 2 mvip, 3 mvien, others unsupported |
| csr_wdata_i | input | DW | Write data |
| csr_rdata_o | output | DW | Read data (combinational) |
| csr_illegal_o | output | 1 | Unsupported select this cycle |
| mip_wstb_o | output | NB | Machine pending bit strobes |
| mip_wdata_o | output | NB | Machine pending write data (strobed bits) |
| mie_wstb_o | output | NB | Machine enable bit strobes |
| mie_wdata_o | output | NB | Machine enable write data (strobed bits) |
| mvip_o | output | NB | Stored virtual-pending register |
| mvien_o | output | NB | Stored virtual-enable register |
| shadow_sie_o | output | NB | Stored shadow-enable register |
| mip_wmask_eff_o | output | NB | Effective writable mask of machine pending |

## Verification
Two functions can fire on the same edge. A write to the virtual-pending register loads its own storage and also strobes machine pending bits. That forwarded strobe depends on the virtual-enable state and on the effective mask, which the enable register itself narrows at bit 9. The bench provokes this with directed writes under mvien bit 9 set and cleared and with bit 5 writable and not writable. Random traffic follows, with the delegation, mask and pending inputs changing. A behavioural model computes both effects, the next stored value and the strobe pattern, and every clock compares them with the outputs.

// File: rtl/sirq_alias_pkg.sv
package sirq_alias_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_SIP   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SIE   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MVIP  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MVIEN = 3'd3;

  // bit positions whose behaviour is special
  localparam int SW_BIT  = 1;
  localparam int TMR_BIT = 5;
  localparam int EXT_BIT = 9;
  // bits that never show through the supervisor views
  localparam logic [13:0] HIDDEN_14 = 14'h1444;

  typedef struct packed {
    logic sip;
    logic sie;
    logic mvip;
    logic mvien;
    logic bad;
  } sel_dec_t;

  function automatic sel_dec_t decode_sel(logic req, logic [SEL_W-1:0] sel);
    sel_dec_t d;
    d = '0;
    if (req) begin
      case (sel)
        SEL_SIP:   d.sip   = 1'b1;
        SEL_SIE:   d.sie   = 1'b1;
        SEL_MVIP:  d.mvip  = 1'b1;
        SEL_MVIEN: d.mvien = 1'b1;
        default:   d.bad   = 1'b1;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/sirq_alias_state.sv
module sirq_alias_state #(
  parameter int NB = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] stb,
  input  logic [NB-1:0] d,
  output logic [NB-1:0] q
);
  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (stb[i]) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/sirq_alias_view.sv
module sirq_alias_view
  import sirq_alias_pkg::*;
#(
  parameter int NB = 14,
  parameter int DW = 32
) (
  input  sel_dec_t      dec,
  input  logic [NB-1:0] mip,
  input  logic [NB-1:0] mie,
  input  logic [NB-1:0] mideleg,
  input  logic [NB-1:0] alias_m,
  input  logic [NB-1:0] eff_m,
  input  logic [NB-1:0] mvip_q,
  input  logic [NB-1:0] mvien_q,
  input  logic [NB-1:0] ssie_q,
  output logic [DW-1:0] rdata,
  output logic          illegal
);
  localparam logic [NB-1:0] HID = NB'(HIDDEN_14);

  logic [NB-1:0] sip_v, sie_v, mvip_v;

  always_comb begin
    sip_v  = ((mip & mideleg & ~alias_m) | (mvip_q & alias_m)) & ~HID;
    sie_v  = ((mie & mideleg & ~alias_m) | (ssie_q & alias_m)) & ~HID;
    mvip_v = mvip_q;
    mvip_v[SW_BIT]  = mvien_q[SW_BIT] ? mvip_q[SW_BIT] : mip[SW_BIT];
    mvip_v[TMR_BIT] = eff_m[TMR_BIT] & mip[TMR_BIT];
    rdata = '0;
    if (dec.sip)        rdata[NB-1:0] = sip_v;
    else if (dec.sie)   rdata[NB-1:0] = sie_v;
    else if (dec.mvip)  rdata[NB-1:0] = mvip_v;
    else if (dec.mvien) rdata[NB-1:0] = mvien_q;
  end

  assign illegal = dec.bad;
endmodule

// File: rtl/sirq_alias_wdec.sv
module sirq_alias_wdec
  import sirq_alias_pkg::*;
#(
  parameter int NB = 14
) (
  input  sel_dec_t      dec,
  input  logic          we,
  input  logic [NB-1:0] mideleg,
  input  logic [NB-1:0] alias_m,
  input  logic [NB-1:0] eff_m,
  input  logic [NB-1:0] mvien_q,
  output logic [NB-1:0] mip_stb,
  output logic [NB-1:0] mie_stb,
  output logic [NB-1:0] mvip_stb,
  output logic [NB-1:0] ssie_stb,
  output logic          mvien_we
);
  localparam logic [NB-1:0] HID = NB'(HIDDEN_14);

  always_comb begin
    mip_stb  = '0;
    mie_stb  = '0;
    mvip_stb = '0;
    ssie_stb = '0;
    mvien_we = 1'b0;
    if (we) begin
      if (dec.sip) begin
        mip_stb  = mideleg & eff_m & ~HID;
        mvip_stb = alias_m & ~HID;
      end
      if (dec.sie) begin
        ssie_stb = alias_m & ~HID;
        mie_stb  = mideleg & ~HID;
      end
      if (dec.mvip) begin
        mvip_stb         = '1;
        mip_stb[SW_BIT]  = ~mvien_q[SW_BIT];
        mip_stb[EXT_BIT] = ~mvien_q[EXT_BIT];
        mip_stb[TMR_BIT] = eff_m[TMR_BIT];
      end
      if (dec.mvien) mvien_we = 1'b1;
    end
  end
endmodule

// File: rtl/sirq_alias.sv
module sirq_alias
  import sirq_alias_pkg::*;
#(
  parameter int NB = 14,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NB-1:0]     mip_i,
  input  logic [NB-1:0]     mie_i,
  input  logic [NB-1:0]     mideleg_i,
  input  logic [NB-1:0]     mip_wmask_i,
  input  logic              csr_req_i,
  input  logic              csr_we_i,
  input  logic [SEL_W-1:0]  csr_sel_i,
  input  logic [DW-1:0]     csr_wdata_i,
  output logic [DW-1:0]     csr_rdata_o,
  output logic              csr_illegal_o,
  output logic [NB-1:0]     mip_wstb_o,
  output logic [NB-1:0]     mip_wdata_o,
  output logic [NB-1:0]     mie_wstb_o,
  output logic [NB-1:0]     mie_wdata_o,
  output logic [NB-1:0]     mvip_o,
  output logic [NB-1:0]     mvien_o,
  output logic [NB-1:0]     shadow_sie_o,
  output logic [NB-1:0]     mip_wmask_eff_o
);
  localparam logic [NB-1:0] EXT_ONEHOT = NB'(1) << EXT_BIT;

  sel_dec_t      dec;
  logic [NB-1:0] alias_m, eff_m, wd;
  logic [NB-1:0] mvip_stb, ssie_stb;
  logic          mvien_we;

  assign dec     = decode_sel(csr_req_i, csr_sel_i);
  assign wd      = csr_wdata_i[NB-1:0];
  assign alias_m = mvien_o & ~mideleg_i;
  assign eff_m   = mip_wmask_i & ~(mvien_o & EXT_ONEHOT);
  assign mip_wmask_eff_o = eff_m;

  sirq_alias_view #(.NB(NB), .DW(DW)) u_view (
    .dec(dec), .mip(mip_i), .mie(mie_i), .mideleg(mideleg_i),
    .alias_m(alias_m), .eff_m(eff_m), .mvip_q(mvip_o), .mvien_q(mvien_o),
    .ssie_q(shadow_sie_o), .rdata(csr_rdata_o), .illegal(csr_illegal_o)
  );

  sirq_alias_wdec #(.NB(NB)) u_wdec (
    .dec(dec), .we(csr_we_i), .mideleg(mideleg_i), .alias_m(alias_m),
    .eff_m(eff_m), .mvien_q(mvien_o), .mip_stb(mip_wstb_o),
    .mie_stb(mie_wstb_o), .mvip_stb(mvip_stb), .ssie_stb(ssie_stb),
    .mvien_we(mvien_we)
  );

  assign mip_wdata_o = wd & mip_wstb_o;
  assign mie_wdata_o = wd & mie_wstb_o;

  sirq_alias_state #(.NB(NB)) u_mvip (
    .clk(clk), .rst(rst), .stb(mvip_stb), .d(wd), .q(mvip_o)
  );
  sirq_alias_state #(.NB(NB)) u_mvien (
    .clk(clk), .rst(rst), .stb({NB{mvien_we}}), .d(wd), .q(mvien_o)
  );
  sirq_alias_state #(.NB(NB)) u_ssie (
    .clk(clk), .rst(rst), .stb(ssie_stb), .d(wd), .q(shadow_sie_o)
  );
endmodule

// File: rtl/sirq_alias_chk.sv
module sirq_alias_chk #(
  parameter int NB = 14,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          csr_req_i,
  input logic          csr_we_i,
  input logic [2:0]    csr_sel_i,
  input logic [DW-1:0] csr_wdata_i,
  input logic [DW-1:0] csr_rdata_o,
  input logic          csr_illegal_o,
  input logic [NB-1:0] mip_wstb_o,
  input logic [NB-1:0] mie_wstb_o,
  input logic [NB-1:0] mvip_o,
  input logic [NB-1:0] mvien_o,
  input logic [NB-1:0] shadow_sie_o,
  input logic [NB-1:0] mip_wmask_eff_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mvip_o == '0 && mvien_o == '0 && shadow_sie_o == '0));

  // R4
  hidden_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_req_i && csr_sel_i <= 3'd1) |-> ((csr_rdata_o[NB-1:0] & NB'(14'h1444)) == '0));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(csr_req_i && csr_we_i && csr_sel_i == 3'd1)) |=> $stable(shadow_sie_o));

  // R9
  ext_ro_chk: assert property (@(posedge clk) disable iff (rst)
    mvien_o[9] |-> !mip_wmask_eff_o[9]);

  // R9
  mvien_load_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_req_i && csr_we_i && csr_sel_i == 3'd3) |=> (mvien_o == $past(csr_wdata_i[NB-1:0])));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    csr_illegal_o |-> (csr_rdata_o == '0 && mip_wstb_o == '0 && mie_wstb_o == '0));

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    csr_illegal_o |=> ($stable(mvip_o) && $stable(mvien_o) && $stable(shadow_sie_o)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_req_i |-> (csr_rdata_o == '0 && !csr_illegal_o && mip_wstb_o == '0 && mie_wstb_o == '0));
endmodule

bind sirq_alias sirq_alias_chk #(.NB(NB), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .csr_req_i(csr_req_i), .csr_we_i(csr_we_i),
  .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
  .csr_illegal_o(csr_illegal_o), .mip_wstb_o(mip_wstb_o), .mie_wstb_o(mie_wstb_o),
  .mvip_o(mvip_o), .mvien_o(mvien_o), .shadow_sie_o(shadow_sie_o),
  .mip_wmask_eff_o(mip_wmask_eff_o)
);

// File: tb/sirq_alias_bench.sv
module sirq_alias_bench;
  localparam int NB = 14;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB-1:0] mip_i = '0, mie_i = '0, mideleg_i = '0, mip_wmask_i = '0;
  logic csr_req_i = 1'b0, csr_we_i = 1'b0;
  logic [2:0] csr_sel_i = '0;
  logic [DW-1:0] csr_wdata_i = '0;
  logic [DW-1:0] csr_rdata_o;
  logic csr_illegal_o;
  logic [NB-1:0] mip_wstb_o, mip_wdata_o, mie_wstb_o, mie_wdata_o;
  logic [NB-1:0] mvip_o, mvien_o, shadow_sie_o, mip_wmask_eff_o;

  always #4 clk = ~clk;

  sirq_alias #(.NB(NB), .DW(DW)) u_sirq_alias (
    .clk(clk), .rst(rst), .mip_i(mip_i), .mie_i(mie_i), .mideleg_i(mideleg_i),
    .mip_wmask_i(mip_wmask_i), .csr_req_i(csr_req_i), .csr_we_i(csr_we_i),
    .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .csr_illegal_o(csr_illegal_o), .mip_wstb_o(mip_wstb_o), .mip_wdata_o(mip_wdata_o),
    .mie_wstb_o(mie_wstb_o), .mie_wdata_o(mie_wdata_o), .mvip_o(mvip_o),
    .mvien_o(mvien_o), .shadow_sie_o(shadow_sie_o), .mip_wmask_eff_o(mip_wmask_eff_o)
  );

  // behavioural model state
  logic [NB-1:0] m_mip, m_mie, m_deleg, m_base, m_mvip, m_mvien, m_ssie;
  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; csr_req_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_mvip = '0; m_mvien = '0; m_ssie = '0;
    #1;
    chk("R1", "mvip after reset", DW'(mvip_o), '0);
    chk("R1", "mvien after reset", DW'(mvien_o), '0);
    chk("R1", "shadow after reset", DW'(shadow_sie_o), '0);
  endtask

  task automatic step(bit req, bit we, logic [2:0] sel, logic [DW-1:0] wd);
    logic [NB-1:0] e_eff, e_sip, e_sie, e_mvr, e_mipstb, e_miestb, e_mvipstb, e_ssiestb;
    logic [DW-1:0] e_rd;
    logic [NB-1:0] w;
    string tg;
    w = wd[NB-1:0];
    @(negedge clk);
    mip_i = m_mip; mie_i = m_mie; mideleg_i = m_deleg; mip_wmask_i = m_base;
    csr_req_i = req; csr_we_i = we; csr_sel_i = sel; csr_wdata_i = wd;
    #1;
    e_mipstb = '0; e_miestb = '0; e_mvipstb = '0; e_ssiestb = '0;
    for (int i = 0; i < NB; i++) begin
      bit hid, al;
      hid = (i == 2) || (i == 6) || (i == 10) || (i == 12);
      al  = !m_deleg[i] && m_mvien[i];
      e_eff[i] = (i == 9) ? (m_base[i] && !m_mvien[i]) : m_base[i];
      e_sip[i] = hid ? 1'b0 : (al ? m_mvip[i] : (m_deleg[i] & m_mip[i]));
      e_sie[i] = hid ? 1'b0 : (al ? m_ssie[i] : (m_deleg[i] & m_mie[i]));
      if (i == 1 && !m_mvien[1]) e_mvr[i] = m_mip[1];
      else if (i == 5)           e_mvr[i] = e_eff[5] & m_mip[5];
      else                       e_mvr[i] = m_mvip[i];
      if (req && we && sel == 3'd0 && !hid) begin
        e_mipstb[i]  = m_deleg[i] && e_eff[i];
        e_mvipstb[i] = al;
      end
      if (req && we && sel == 3'd1 && !hid) begin
        e_ssiestb[i] = al;
        e_miestb[i]  = m_deleg[i];
      end
      if (req && we && sel == 3'd2) begin
        e_mvipstb[i] = 1'b1;
        e_mipstb[i]  = ((i == 1 || i == 9) && !m_mvien[i]) || (i == 5 && e_eff[5]);
      end
    end
    e_rd = '0;
    if (!req) tg = "R11";
    else case (sel)
      3'd0: begin tg = "R2"; e_rd = DW'(e_sip); end
      3'd1: begin tg = "R3"; e_rd = DW'(e_sie); end
      3'd2: begin tg = "R7"; e_rd = DW'(e_mvr); end
      3'd3: begin tg = "R9"; e_rd = DW'(m_mvien); end
      default: tg = "R10";
    endcase
    chk(tg, "read data", csr_rdata_o, e_rd);
    chk(tg, "illegal flag", DW'(csr_illegal_o), DW'(req && sel > 3'd3));
    if (req && sel <= 3'd1)
      chk("R4", "hidden bits", csr_rdata_o & 32'h1444, '0);
    if (req && we && sel == 3'd2) tg = "R8";
    else if (req && we && sel == 3'd0) tg = "R6";
    else if (req && we && sel == 3'd1) tg = "R5";
    chk(tg, "mip strobe", DW'(mip_wstb_o), DW'(e_mipstb));
    chk(tg, "mip data", DW'(mip_wdata_o & e_mipstb), DW'(w & e_mipstb));
    chk(tg, "mie strobe", DW'(mie_wstb_o), DW'(e_miestb));
    chk(tg, "mie data", DW'(mie_wdata_o & e_miestb), DW'(w & e_miestb));
    chk("R8", "mvip state", DW'(mvip_o), DW'(m_mvip));
    chk("R9", "mvien state", DW'(mvien_o), DW'(m_mvien));
    chk("R5", "shadow state", DW'(shadow_sie_o), DW'(m_ssie));
    chk("R9", "effective mask", DW'(mip_wmask_eff_o), DW'(e_eff));
    @(posedge clk);
    m_mvip = (m_mvip & ~e_mvipstb) | (w & e_mvipstb);
    m_ssie = (m_ssie & ~e_ssiestb) | (w & e_ssiestb);
    if (req && we && sel == 3'd3) m_mvien = w;
    m_mip = (m_mip & ~e_mipstb) | (w & e_mipstb);
    m_mie = (m_mie & ~e_miestb) | (w & e_miestb);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_mip = '0; m_mie = '0; m_deleg = 14'h0222; m_base = 14'h3FFF;
    m_mvip = 'x; m_mvien = 'x; m_ssie = 'x;
    repeat (3) @(posedge clk);
    do_reset();                                  // R1
    step(0, 0, 3'd0, '0);                        // R11 idle
    step(1, 1, 3'd3, 32'h2208);                  // R9 aliases bits 3, 13
    step(1, 1, 3'd0, 32'h3FFF);                  // R6 delegated + aliased
    step(1, 0, 3'd0, '0);                        // R2, R4
    step(1, 1, 3'd1, 32'h3FFF);                  // R5
    step(1, 0, 3'd1, '0);                        // R3
    step(1, 0, 3'd2, '0);                        // R7
    step(1, 1, 3'd2, 32'h0222);                  // R8 with mvien[9] set
    step(1, 1, 3'd3, 32'h0000);                  // R9 clear
    step(1, 1, 3'd2, 32'h0202);                  // R8 bits 1, 5, 9
    step(1, 0, 3'd2, '0);                        // R7 bit 1 alias
    m_base = 14'h3FDF;
    step(1, 0, 3'd2, '0);                        // R7 bit 5 not writable
    step(1, 1, 3'd2, 32'h3FFF);                  // R8 no bit-5 strobe
    step(1, 1, 3'd5, 32'hFFFF);                  // R10
    step(1, 0, 3'd7, '0);                        // R10
    do_reset();                                  // R1 mid-run
    for (int n = 0; n < 800; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0) begin
        m_deleg = 14'($urandom); m_base = 14'($urandom);
        m_mip = 14'($urandom);   m_mie = 14'($urandom);
      end
      step(r[3] | r[4], r[5], r[8:6], $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule